// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Front End

This block is the byte-wide register front end of a two-channel asynchronous serial controller. A host issues single-cycle read or write accesses on a 6-bit address. The block steers each access to one of two per-channel register windows, or to a small set of registers shared by both channels. The transmit and receive datapaths of each channel sit outside the block. The front end passes them a read or write strobe and a window offset. It takes back their read data and their transmitter-ready and receiver-ready flags. The channel datapaths take write data straight from `bus_wdata`.

The shared registers are:
- an interrupt mask, which is write-only;
- an interrupt status view, read at the same address that loads the mask;
- a modem-control output register, changed only through a write-one-to-set address and a write-one-to-clear address and driven out inverted;
- an auxiliary control register;
- an output-configuration register;
- a read-only view of the active-low modem input pins.

The interrupt request is a level: it is high whenever any ready flag meets a set mask bit. Read data is registered. It appears one clock after the read and holds until the next read. The block has no state machine. Its only state is the read-data register, the mask, the output register and the two control registers.

Top module: `dual_serial_regif`

## Requirements
- R1: After reset, `bus_rdata` is 0x00, `irq` is low, `aux_ctrl` and `port_cfg` are 0x00 and `modem_out_n` is 0xFF (all pins high).
- R2: An access with address bit 4 low goes to a channel window. The window is channel A when address bit 5 is 0 and channel B when it is 1. The window offset is address bits 3:0 on `ch_off`. Exactly one bit of `ch_rd_stb` (on a read) or `ch_wr_stb` (on a write) pulses, in the same cycle; bit 0 is channel A. An access with address bit 4 high raises no channel strobe.
- R3: A read in a channel window returns that channel's read data on `bus_rdata` one clock later. Channel A's data is `ch_rdata[7:0]` and channel B's is `ch_rdata[15:8]`.
- R4: A read of address 0x14 returns the interrupt status: bit 0 is channel A transmitter ready, bit 1 is channel A receiver ready, bit 4 is channel B transmitter ready and bit 5 is channel B receiver ready. All other bits read 0.
- R5: A write to 0x14 loads the interrupt mask, whose bits line up with the status bits. The mask cannot be read back, because a read of 0x14 still returns status. `irq` is high exactly while the status ANDed with the mask is nonzero, in the same cycle as the ready flags.
- R6: A write to 0x38 sets every output-register bit written as 1. Bits written as 0 keep their value.
- R7: A write to 0x3C clears every output-register bit written as 1. Bits written as 0 keep their value.
- R8: `modem_out_n` is the bitwise inverse of the output register, so a set bit drives its pin low.
- R9: A read of 0x34 returns the raw `modem_in_n` pins in bits 5:0, with bits 7:6 zero.
- R10: A write to 0x10 loads `aux_ctrl` (bit 7 selects the baud-rate set). A write to 0x34 loads `port_cfg`. Each appears on the next clock and leaves the other registers unchanged.
- R11: Reads of unused shared addresses return 0x00. Writes to unused shared addresses change no output.
- R12: `bus_rdata` holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register address |
| bus_rd | input | 1 | Read access this cycle |
| bus_wr | input | 1 | Write access this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ch_off | output | 4 | Offset within the channel window |
| ch_rd_stb | output | 2 | Per-channel read strobe |
| ch_wr_stb | output | 2 | Per-channel write strobe |
| ch_rdata | input | 16 | Read data from channel datapaths (A low byte) |
| tx_rdy | input | 2 | Transmitter-ready flags (bit 0 is A) |
| rx_rdy | input | 2 | Receiver-ready flags (bit 0 is A) |
| modem_in_n | input | 6 | Active-low modem input pins |
| modem_out_n | output | 8 | Active-low modem output pins |
| aux_ctrl | output | 8 | Auxiliary control register |
| port_cfg | output | 8 | Output-configuration register |
| irq | output | 1 | Active-high level interrupt request |

## Verification
The write-only mask can only be seen through `irq`. A wrong mask bit therefore shows up only when the matching ready flag rises, in that same cycle. The bench raises each flag against single-bit masks for that reason. A set/clear error in the output register stays latched and shows on `modem_out_n` one clock after the write. Chained set and clear writes show whether earlier bits are kept. A mis-decode between the shared window and a channel window appears at once as a stray strobe, and one clock later as wrong `bus_rdata`. Reads that alias the mask address expose a design that returns the mask instead of the status.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_AUX  = 6'h10;
    localparam logic [ADDR_W-1:0] ADR_IRQ  = 6'h14;
    localparam logic [ADDR_W-1:0] ADR_PORT = 6'h34;
    localparam logic [ADDR_W-1:0] ADR_SET  = 6'h38;
    localparam logic [ADDR_W-1:0] ADR_CLR  = 6'h3C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_AUX,
        SEL_IRQ,
        SEL_PORT,
        SEL_SET,
        SEL_CLR
    } com_sel_e;

    // shared-window decode for writes
    function automatic com_sel_e decode_wr(input logic [ADDR_W-1:0] a);
        com_sel_e s;
        case (a)
            ADR_AUX:  s = SEL_AUX;
            ADR_IRQ:  s = SEL_IRQ;
            ADR_PORT: s = SEL_PORT;
            ADR_SET:  s = SEL_SET;
            ADR_CLR:  s = SEL_CLR;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // shared-window decode for reads: only status and input pins exist
    function automatic com_sel_e decode_rd(input logic [ADDR_W-1:0] a);
        com_sel_e s;
        case (a)
            ADR_IRQ:  s = SEL_IRQ;
            ADR_PORT: s = SEL_PORT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dsr_addr_dec.sv
module dsr_addr_dec
    import dsr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output com_sel_e          com_rd,
    output com_sel_e          com_wr,
    output logic [NUM_CH-1:0] ch_rd,
    output logic [NUM_CH-1:0] ch_wr,
    output logic [OFF_W-1:0]  ch_off
);
    localparam int COM_BIT = OFF_W;
    localparam int CH_BIT  = OFF_W + 1;

    logic in_ch;
    assign in_ch  = !addr[COM_BIT];
    assign ch_off = addr[OFF_W-1:0];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_rd[c] = rd_en && in_ch && (int'(addr[CH_BIT]) == c);
        assign ch_wr[c] = wr_en && in_ch && (int'(addr[CH_BIT]) == c);
    end

    always_comb begin
        com_rd = (rd_en && !in_ch) ? decode_rd(addr) : SEL_NONE;
        com_wr = (wr_en && !in_ch) ? decode_wr(addr) : SEL_NONE;
    end

    AST_CH_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rd)); // R2
    AST_CH_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_wr)); // R2
    AST_COMMON_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        addr[COM_BIT] |-> (ch_rd == '0 && ch_wr == '0)); // R2
endmodule

// File: rtl/dsr_irq_ctrl.sv
module dsr_irq_ctrl #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 8,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] tx_rdy,
    input  logic [NUM_CH-1:0] rx_rdy,
    output logic [DATA_W-1:0] status,
    output logic              irq
);
    logic [DATA_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // each channel's pair sits STRIDE bits above the previous channel
    always_comb begin
        status = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            status[c*STRIDE]     = tx_rdy[c];
            status[c*STRIDE + 1] = rx_rdy[c];
        end
    end

    assign irq = |(status & mask_q);

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q)); // R5
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|{tx_rdy, rx_rdy})); // R5
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0)); // R5
endmodule

// File: rtl/dsr_out_port.sv
module dsr_out_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aux_we,
    input  logic              cfg_we,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pins_n,
    output logic [DATA_W-1:0] aux_q,
    output logic [DATA_W-1:0] cfg_q
);
    logic [DATA_W-1:0] op_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= '0;
            aux_q <= '0;
            cfg_q <= '0;
        end else begin
            if (set_we)      op_q <= op_q | wdata;
            else if (clr_we) op_q <= op_q & ~wdata;
            if (aux_we) aux_q <= wdata;
            if (cfg_we) cfg_q <= wdata;
        end
    end

    assign pins_n = ~op_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((pins_n & $past(wdata)) == '0)); // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((~pins_n & $past(wdata)) == '0)); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(pins_n)); // R8
    AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_we |=> $stable(aux_q)); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
    import dsr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int OFF_W  = 4,
    parameter int IN_W   = 6,
    parameter int STRIDE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [OFF_W-1:0]         ch_off,
    output logic [NUM_CH-1:0]        ch_rd_stb,
    output logic [NUM_CH-1:0]        ch_wr_stb,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata,
    input  logic [NUM_CH-1:0]        tx_rdy,
    input  logic [NUM_CH-1:0]        rx_rdy,
    input  logic [IN_W-1:0]          modem_in_n,
    output logic [DATA_W-1:0]        modem_out_n,
    output logic [DATA_W-1:0]        aux_ctrl,
    output logic [DATA_W-1:0]        port_cfg,
    output logic                     irq
);
    localparam int PAD_W = DATA_W - IN_W;

    com_sel_e          com_rd;
    com_sel_e          com_wr;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] in_ext;

    dsr_addr_dec #(.NUM_CH(NUM_CH), .OFF_W(OFF_W)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .rd_en  (bus_rd),
        .wr_en  (bus_wr),
        .com_rd (com_rd),
        .com_wr (com_wr),
        .ch_rd  (ch_rd_stb),
        .ch_wr  (ch_wr_stb),
        .ch_off (ch_off)
    );

    dsr_irq_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .STRIDE(STRIDE)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (com_wr == SEL_IRQ),
        .wdata   (bus_wdata),
        .tx_rdy  (tx_rdy),
        .rx_rdy  (rx_rdy),
        .status  (status),
        .irq     (irq)
    );

    dsr_out_port #(.DATA_W(DATA_W)) u_port (
        .clk    (clk),
        .rst_n  (rst_n),
        .aux_we (com_wr == SEL_AUX),
        .cfg_we (com_wr == SEL_PORT),
        .set_we (com_wr == SEL_SET),
        .clr_we (com_wr == SEL_CLR),
        .wdata  (bus_wdata),
        .pins_n (modem_out_n),
        .aux_q  (aux_ctrl),
        .cfg_q  (port_cfg)
    );

    assign in_ext = {{PAD_W{1'b0}}, modem_in_n};

    always_comb begin
        rd_next = '0;
        if (|ch_rd_stb) begin
            for (int c = 0; c < NUM_CH; c++)
                if (ch_rd_stb[c]) rd_next = ch_rdata[c*DATA_W +: DATA_W];
        end else begin
            unique case (com_rd)
                SEL_IRQ:  rd_next = status;
                SEL_PORT: rd_next = in_ext;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_PORT) |=> (bus_rdata[DATA_W-1:IN_W] == '0)); // R9
endmodule

// File: tb/dual_serial_regif_tb_top.sv
module dual_serial_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  ch_off;
    logic [1:0]  ch_rd_stb;
    logic [1:0]  ch_wr_stb;
    logic [15:0] ch_rdata = '0;
    logic [1:0]  tx_rdy = '0;
    logic [1:0]  rx_rdy = '0;
    logic [5:0]  modem_in_n = '1;
    logic [7:0]  modem_out_n;
    logic [7:0]  aux_ctrl;
    logic [7:0]  port_cfg;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dual_serial_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_off(ch_off), .ch_rd_stb(ch_rd_stb), .ch_wr_stb(ch_wr_stb),
        .ch_rdata(ch_rdata), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
        .modem_in_n(modem_in_n), .modem_out_n(modem_out_n),
        .aux_ctrl(aux_ctrl), .port_cfg(port_cfg), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 aux", aux_ctrl, 8'h00);
        chk("R1 cfg", port_cfg, 8'h00);
        chk("R1 modem_out_n", modem_out_n, 8'hFF);
    endtask

    task automatic t_chan_decode;
        @(negedge clk);
        bus_addr = 6'h0C; bus_rd = 1'b1;
        #5;
        chk("R2 rd stb A", ch_rd_stb, 2'b01);
        chk("R2 off A", ch_off, 4'hC);
        chk("R2 no wr stb", ch_wr_stb, 2'b00);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 6'h24; bus_wr = 1'b1;
        #5;
        chk("R2 wr stb B", ch_wr_stb, 2'b10);
        chk("R2 off B", ch_off, 4'h4);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h14; bus_rd = 1'b1;
        #5;
        chk("R2 shared no strobe", {ch_rd_stb, ch_wr_stb}, 4'b0000);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_chan_read;
        logic [7:0] d;
        ch_rdata = 16'hB2A1;
        bus_read(6'h0C, d);
        chk("R3 chan A data", d, 8'hA1);
        bus_read(6'h2C, d);
        chk("R3 chan B data", d, 8'hB2);
    endtask

    task automatic t_status;
        logic [7:0] d;
        tx_rdy = 2'b01; rx_rdy = 2'b10;
        bus_read(6'h14, d);
        chk("R4 status A tx B rx", d, 8'h21);
        tx_rdy = 2'b10; rx_rdy = 2'b01;
        bus_read(6'h14, d);
        chk("R4 status B tx A rx", d, 8'h12);
        tx_rdy = 2'b00; rx_rdy = 2'b00;
    endtask

    task automatic t_irq;
        logic [7:0] d;
        bus_write(6'h14, 8'h02);
        #5;
        chk("R5 irq low no ready", irq, 0);
        rx_rdy = 2'b01;
        #5;
        chk("R5 irq A rx masked in", irq, 1);
        tx_rdy = 2'b11; rx_rdy = 2'b00;
        #5;
        chk("R5 irq tx masked out", irq, 0);
        tx_rdy = 2'b00;
        bus_read(6'h14, d);
        chk("R5 mask not readable", d, 8'h00);
        bus_write(6'h14, 8'h10);
        tx_rdy = 2'b10;
        #5;
        chk("R5 irq B tx", irq, 1);
        tx_rdy = 2'b01;
        #5;
        chk("R5 irq A tx not masked", irq, 0);
        tx_rdy = 2'b00;
        bus_write(6'h14, 8'h00);
    endtask

    task automatic t_port;
        bus_write(6'h38, 8'h05);
        chk("R6 R8 set 05", modem_out_n, 8'hFA);
        bus_write(6'h38, 8'h80);
        chk("R6 set keeps others", modem_out_n, 8'h7A);
        bus_write(6'h3C, 8'h04);
        chk("R7 clear 04", modem_out_n, 8'h7E);
        bus_write(6'h3C, 8'h00);
        chk("R7 clear zero no change", modem_out_n, 8'h7E);
        bus_write(6'h38, 8'h00);
        chk("R6 set zero no change", modem_out_n, 8'h7E);
    endtask

    task automatic t_inport;
        logic [7:0] d;
        modem_in_n = 6'b101010;
        bus_read(6'h34, d);
        chk("R9 input pins", d, 8'h2A);
        modem_in_n = 6'b111111;
        bus_read(6'h34, d);
        chk("R9 input pins high", d, 8'h3F);
    endtask

    task automatic t_aux;
        bus_write(6'h10, 8'h80);
        chk("R10 aux", aux_ctrl, 8'h80);
        chk("R10 cfg untouched", port_cfg, 8'h00);
        bus_write(6'h34, 8'h3C);
        chk("R10 cfg", port_cfg, 8'h3C);
        chk("R10 aux kept", aux_ctrl, 8'h80);
        chk("R10 out kept", modem_out_n, 8'h7E);
    endtask

    task automatic t_unused;
        logic [7:0] d;
        bus_write(6'h18, 8'hFF);
        bus_write(6'h30, 8'hFF);
        bus_write(6'h1C, 8'hFF);
        chk("R11 aux unchanged", aux_ctrl, 8'h80);
        chk("R11 cfg unchanged", port_cfg, 8'h3C);
        chk("R11 out unchanged", modem_out_n, 8'h7E);
        rx_rdy = 2'b11; tx_rdy = 2'b11;
        #5;
        chk("R11 mask unchanged", irq, 0);
        rx_rdy = 2'b00; tx_rdy = 2'b00;
        bus_read(6'h18, d);
        chk("R11 read 18", d, 8'h00);
        bus_read(6'h3C, d);
        chk("R11 read 3C", d, 8'h00);
        bus_read(6'h10, d);
        chk("R11 read aux addr", d, 8'h00);
    endtask

    task automatic t_hold;
        logic [7:0] d;
        ch_rdata = 16'h5A5A;
        bus_read(6'h20, d);
        chk("R12 read value", d, 8'h5A);
        ch_rdata = 16'h0000;
        repeat (3) @(negedge clk);
        chk("R12 held", bus_rdata, 8'h5A);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual 0x0 expected 0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chan_decode();
        t_chan_read();
        t_status();
        t_irq();
        t_port();
        t_inport();
        t_aux();
        t_unused();
        t_hold();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule